// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This unit multiplies two signed 16-bit operands and adds the 32-bit product into an accumulator pair made of a high word and a low word. Each strobe on `mac_go` does one accumulation, and the sum can be read on `acc_hi`/`acc_lo` in the next cycle. The style of accumulation is chosen per strobe by `mac_sat`.

- With `mac_sat` low, the pair behaves as a wide signed accumulator whose high word keeps only ten significant bits.
- With `mac_sat` high, the sum is limited to 32 bits. Any overflow is clamped, and bit 0 of the high word records it. That bit stays set until it is cleared or overwritten.

Software can load either half through `wr_hi`/`wr_lo`, and `clr` zeroes both halves. A second command, `mul_go`, forms the full 64-bit product of two 32-bit operands and writes it into the pair. The operands are treated as signed when `mul_signed` is high and as unsigned otherwise. The product is built in two passes over one shared 33x17 multiplier:

- `ST_IDLE` to `ST_MUL2`, on an accepted `mul_go`: the low partial product is loaded.
- `ST_MUL2` to `ST_IDLE`, always: the shifted high partial product is added.

`busy` is high while the controller is in `ST_MUL2`.

Top module: `smac_unit`

## Requirements
- R1: The MAC product is the signed 16x16 product of `op_a` and `op_b`, sign-extended to 32 bits, and it is added in the cycle `mac_go` is sampled. The new pair is visible after that clock edge.
- R2: With `mac_sat`=0, the low word becomes the 32-bit sum of the old low word and the product. The high word becomes the old high word, plus all-ones when the product is negative, plus the unsigned carry out of the low-word sum.
- R3: With `mac_sat`=0, the high word is then sign-extended from bit 9, so bits 31:10 equal bit 9.
- R4: With `mac_sat`=1 and no overflow, the low word takes the 32-bit sum and the high word is left unchanged.
- R5: With `mac_sat`=1, overflow means the product and the old low word have the same sign and the sum's sign differs from it. On overflow the low word becomes 0x7FFFFFFF for a non-negative product or 0x80000000 for a negative one, and bit 0 of the high word is set.
- R6: Once set, bit 0 of the high word stays set through later saturating accumulations. Only `clr`, a high-word write or a full multiply changes it.
- R7: `clr` zeroes both halves at the next edge. It has priority over every other input, and in `ST_MUL2` it abandons the multiply and returns to `ST_IDLE` with `busy` low.
- R8: In `ST_IDLE`, `wr_hi`/`wr_lo` load `wr_data` into the high/low word. A write in the same cycle as `mac_go` or `mul_go` wins, and the strobe is dropped.
- R9: `mul_go` in `ST_IDLE` yields the 64-bit product of `mul_a` and `mul_b` in {`acc_hi`,`acc_lo`} two edges later. The operands are signed when `mul_signed`=1 and unsigned when it is 0. `busy` is high for exactly the one cycle in between.
- R10: While `busy` is high, `mac_go`, `mul_go`, `wr_hi` and `wr_lo` are ignored, and the multiply result is unaffected by them.
- R11: When `mul_go` and `mac_go` are both high in `ST_IDLE`, the multiply is performed and the accumulation is dropped.
- R12: After reset both halves read 0 and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Zero both accumulator halves |
| mac_go | input | 1 | Accumulate strobe |
| mac_sat | input | 1 | 1: saturating 32-bit mode, 0: wide mode |
| op_a | input | 16 | Signed MAC operand |
| op_b | input | 16 | Signed MAC operand |
| mul_go | input | 1 | Start a full 32x32 multiply |
| mul_signed | input | 1 | 1: signed operands, 0: unsigned |
| mul_a | input | 32 | Full-multiply operand |
| mul_b | input | 32 | Full-multiply operand |
| wr_hi | input | 1 | Load high word from `wr_data` |
| wr_lo | input | 1 | Load low word from `wr_data` |
| wr_data | input | 32 | Write data for either half |
| acc_hi | output | 32 | High accumulator word |
| acc_lo | output | 32 | Low accumulator word |
| busy | output | 1 | Full multiply in its second pass |

## Verification
Two functions can land on the same edge:
- An accumulation strobe together with a register write or a clear.
- A multiply start together with an accumulation strobe.

The bench raises both inputs on one falling edge. It then expects only the winner's effect at the next sample: the written value, zeros, or the multiply's busy cycle followed by its product. It also asserts every strobe and write during the multiply's busy cycle, or a clear there. It judges the outcome by comparing the final pair against a product computed independently of the disturbance.

// File: rtl/smac_pkg.sv
package smac_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_MUL2 = 1'b1
    } smac_state_e;

    typedef enum logic [2:0] {
        ACT_NONE  = 3'd0,
        ACT_CLEAR = 3'd1,
        ACT_WRITE = 3'd2,
        ACT_MAC   = 3'd3,
        ACT_MUL1  = 3'd4,
        ACT_MUL2  = 3'd5
    } smac_act_e;

endpackage

// File: rtl/smac_partial.sv
// Signed multiplier of arbitrary operand widths; full-width result.
module smac_partial #(
    parameter int AW = 33,
    parameter int BW = 17
) (
    input  logic [AW-1:0]    a_i,
    input  logic [BW-1:0]    b_i,
    output logic [AW+BW-1:0] p_o
);
    localparam int PW = AW + BW;

    logic signed [PW-1:0] ax;
    logic signed [PW-1:0] bx;

    assign ax  = {{BW{a_i[AW-1]}}, a_i};
    assign bx  = {{AW{b_i[BW-1]}}, b_i};
    assign p_o = ax * bx;

endmodule

// File: rtl/smac_accum.sv
// Next-value logic for one accumulation in either mode.
module smac_accum #(
    parameter int ACCW   = 32,
    parameter int HIBITS = 10
) (
    input  logic [ACCW-1:0] hi_i,
    input  logic [ACCW-1:0] lo_i,
    input  logic [ACCW-1:0] prod_i,
    input  logic            sat_i,
    output logic [ACCW-1:0] hi_o,
    output logic [ACCW-1:0] lo_o
);
    localparam int SHX = ACCW - HIBITS;

    logic [ACCW:0]   lsum;
    logic [ACCW-1:0] hsum;
    logic [ACCW-1:0] wide_hi;
    logic [ACCW-1:0] clamp;
    logic            ovf;

    always_comb begin
        lsum  = {1'b0, lo_i} + {1'b0, prod_i};
        hsum  = hi_i + {ACCW{prod_i[ACCW-1]}} + {{(ACCW-1){1'b0}}, lsum[ACCW]};
        ovf   = (prod_i[ACCW-1] == lo_i[ACCW-1]) && (lsum[ACCW-1] != prod_i[ACCW-1]);
        clamp = prod_i[ACCW-1] ? {1'b1, {(ACCW-1){1'b0}}} : {1'b0, {(ACCW-1){1'b1}}};
    end

    // High word narrowing: only when fewer significant bits than the word.
    generate
        if (HIBITS < ACCW) begin : g_narrow
            assign wide_hi = ACCW'($signed(hsum << SHX) >>> SHX);
        end else begin : g_full
            assign wide_hi = hsum;
        end
    endgenerate

    always_comb begin
        if (sat_i) begin
            lo_o = ovf ? clamp : lsum[ACCW-1:0];
            hi_o = ovf ? (hi_i | {{(ACCW-1){1'b0}}, 1'b1}) : hi_i;
        end else begin
            lo_o = lsum[ACCW-1:0];
            hi_o = wide_hi;
        end
    end

endmodule

// File: rtl/smac_ctrl.sv
// Controller: resolves input priority and sequences the two-pass multiply.
module smac_ctrl
    import smac_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      wr_any,
    input  logic      mul_go,
    input  logic      mac_go,
    output smac_act_e act,
    output logic      in_mul2
);
    smac_state_e state_q;
    smac_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        act     = ACT_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (clr) begin
                    act = ACT_CLEAR;
                end else if (wr_any) begin
                    act = ACT_WRITE;
                end else if (mul_go) begin
                    act     = ACT_MUL1;
                    state_d = ST_MUL2;
                end else if (mac_go) begin
                    act = ACT_MAC;
                end
            end
            ST_MUL2: begin
                state_d = ST_IDLE;
                act     = clr ? ACT_CLEAR : ACT_MUL2;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign in_mul2 = (state_q == ST_MUL2);

endmodule

// File: rtl/smac_unit.sv
module smac_unit
    import smac_pkg::*;
#(
    parameter int OPW    = 16,
    parameter int HIBITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              mac_go,
    input  logic              mac_sat,
    input  logic [OPW-1:0]    op_a,
    input  logic [OPW-1:0]    op_b,
    input  logic              mul_go,
    input  logic              mul_signed,
    input  logic [2*OPW-1:0]  mul_a,
    input  logic [2*OPW-1:0]  mul_b,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [2*OPW-1:0]  wr_data,
    output logic [2*OPW-1:0]  acc_hi,
    output logic [2*OPW-1:0]  acc_lo,
    output logic              busy
);
    localparam int ACCW  = 2 * OPW;
    localparam int FULLW = 2 * ACCW;
    localparam int HALF  = ACCW / 2;
    localparam int AX    = ACCW + 1;
    localparam int BX    = HALF + 1;
    localparam int PW    = AX + BX;

    smac_act_e        act;
    logic [FULLW-1:0] acc_q;
    logic [ACCW-1:0]  mac_prod;
    logic [ACCW-1:0]  mac_hi;
    logic [ACCW-1:0]  mac_lo;
    logic [AX-1:0]    a_ext;
    logic [AX-1:0]    b_ext;
    logic [AX-1:0]    a_q;
    logic [BX-1:0]    bh_q;
    logic [AX-1:0]    pa;
    logic [BX-1:0]    pb;
    logic [PW-1:0]    part;
    logic [FULLW-1:0] part_sx;

    smac_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_any  (wr_hi | wr_lo),
        .mul_go  (mul_go),
        .mac_go  (mac_go),
        .act     (act),
        .in_mul2 (busy)
    );

    // 16x16 signed product for accumulation.
    smac_partial #(.AW(OPW), .BW(OPW)) u_mac_mul (
        .a_i (op_a),
        .b_i (op_b),
        .p_o (mac_prod)
    );

    smac_accum #(.ACCW(ACCW), .HIBITS(HIBITS)) u_accum (
        .hi_i   (acc_q[FULLW-1:ACCW]),
        .lo_i   (acc_q[ACCW-1:0]),
        .prod_i (mac_prod),
        .sat_i  (mac_sat),
        .hi_o   (mac_hi),
        .lo_o   (mac_lo)
    );

    // Full multiply operands widened by one bit: sign or zero.
    assign a_ext = {mul_signed & mul_a[ACCW-1], mul_a};
    assign b_ext = {mul_signed & mul_b[ACCW-1], mul_b};

    // One shared multiplier: low half of B first, latched high half second.
    assign pa = busy ? a_q  : a_ext;
    assign pb = busy ? bh_q : {1'b0, b_ext[HALF-1:0]};

    smac_partial #(.AW(AX), .BW(BX)) u_full_mul (
        .a_i (pa),
        .b_i (pb),
        .p_o (part)
    );

    assign part_sx = {{(FULLW-PW){part[PW-1]}}, part};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q  <= '0;
            bh_q <= '0;
        end else if (act == ACT_MUL1) begin
            a_q  <= a_ext;
            bh_q <= b_ext[AX-1:HALF];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            unique case (act)
                ACT_CLEAR: acc_q <= '0;
                ACT_WRITE: begin
                    if (wr_hi) acc_q[FULLW-1:ACCW] <= wr_data;
                    if (wr_lo) acc_q[ACCW-1:0]     <= wr_data;
                end
                ACT_MAC:   acc_q <= {mac_hi, mac_lo};
                ACT_MUL1:  acc_q <= part_sx;
                ACT_MUL2:  acc_q <= acc_q + (part_sx << HALF);
                default:   acc_q <= acc_q;
            endcase
        end
    end

    assign acc_hi = acc_q[FULLW-1:ACCW];
    assign acc_lo = acc_q[ACCW-1:0];

endmodule

// File: rtl/smac_unit_chk.sv
module smac_unit_chk #(
    parameter int ACCW   = 32,
    parameter int HIBITS = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clr,
    input logic            mac_go,
    input logic            mac_sat,
    input logic            mul_go,
    input logic            wr_hi,
    input logic            wr_lo,
    input logic [ACCW-1:0] wr_data,
    input logic [ACCW-1:0] acc_hi,
    input logic [ACCW-1:0] acc_lo,
    input logic            busy
);
    localparam logic [ACCW-1:0] MAXP = {1'b0, {(ACCW-1){1'b1}}};
    localparam logic [ACCW-1:0] MINN = {1'b1, {(ACCW-1){1'b0}}};

    logic idle_free;
    logic wide_fire;
    logic sat_fire;

    assign idle_free = !busy && !clr && !wr_hi && !wr_lo && !mul_go;
    assign wide_fire = idle_free && mac_go && !mac_sat;
    assign sat_fire  = idle_free && mac_go && mac_sat;

    assert_wide_hi_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wide_fire |=> (acc_hi[ACCW-1:HIBITS] == {(ACCW-HIBITS){acc_hi[HIBITS-1]}}));

    assert_sat_hi_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sat_fire |=> (acc_hi[ACCW-1:1] == $past(acc_hi[ACCW-1:1])));

    assert_clamp_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_fire && !acc_hi[0]) |=> (!acc_hi[0] || acc_lo == MAXP || acc_lo == MINN));

    assert_sticky_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_fire && acc_hi[0]) |=> acc_hi[0]);

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_hi == '0 && acc_lo == '0 && !busy));

    assert_write_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !clr && wr_lo) |=> (acc_lo == $past(wr_data)));

    assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !clr && !wr_hi && !wr_lo && mul_go) |=> busy);

    assert_busy_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

endmodule

bind smac_unit smac_unit_chk #(.ACCW(ACCW), .HIBITS(HIBITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .mac_go  (mac_go),
    .mac_sat (mac_sat),
    .mul_go  (mul_go),
    .wr_hi   (wr_hi),
    .wr_lo   (wr_lo),
    .wr_data (wr_data),
    .acc_hi  (acc_hi),
    .acc_lo  (acc_lo),
    .busy    (busy)
);

// File: tb/smac_unit_bench.sv
`timescale 1ns/1ps
module smac_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr, mac_go, mac_sat, mul_go, mul_signed, wr_hi, wr_lo;
    logic [15:0] op_a, op_b;
    logic [31:0] mul_a, mul_b, wr_data;
    logic [31:0] acc_hi, acc_lo;
    logic        busy;

    always #2.5 clk = ~clk;

    smac_unit u_smac_unit (
        .clk(clk), .rst_n(rst_n), .clr(clr), .mac_go(mac_go), .mac_sat(mac_sat),
        .op_a(op_a), .op_b(op_b), .mul_go(mul_go), .mul_signed(mul_signed),
        .mul_a(mul_a), .mul_b(mul_b), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_data(wr_data), .acc_hi(acc_hi), .acc_lo(acc_lo), .busy(busy)
    );

    typedef struct {
        int          due;
        logic [31:0] hi;
        logic [31:0] lo;
        logic        bz;
        bit          acc_chk;
        string       req;
    } exp_t;

    exp_t        sb[$];
    exp_t        it;
    int          cyc = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] m_hi = '0;
    logic [31:0] m_lo = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop every expectation due at this falling edge and compare.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            it = sb.pop_front();
            n_vec++;
            if ((it.acc_chk && (acc_hi !== it.hi || acc_lo !== it.lo)) || busy !== it.bz) begin
                n_bad++;
                $display("FAIL %s: got hi=%h lo=%h busy=%b, expected hi=%h lo=%h busy=%b",
                         it.req, acc_hi, acc_lo, busy, it.hi, it.lo, it.bz);
            end
        end
    end

    task automatic push(input logic bz, input bit chk, input string req);
        exp_t e;
        e.due = cyc + 1; e.hi = m_hi; e.lo = m_lo; e.bz = bz; e.acc_chk = chk; e.req = req;
        sb.push_back(e);
    endtask

    task automatic drive_idle();
        clr = 0; mac_go = 0; mac_sat = 0; mul_go = 0; mul_signed = 0;
        wr_hi = 0; wr_lo = 0; op_a = '0; op_b = '0; mul_a = '0; mul_b = '0; wr_data = '0;
    endtask

    // Reference model of one accumulation, from R1..R5.
    task automatic model_mac(input logic [15:0] a, input logic [15:0] b, input logic sat);
        int          ia, ib;
        logic [31:0] pr, s;
        logic [63:0] t;
        ia = {{16{a[15]}}, a};
        ib = {{16{b[15]}}, b};
        pr = ia * ib;
        if (!sat) begin
            t    = {m_hi, m_lo} + {{32{pr[31]}}, pr};
            m_lo = t[31:0];
            m_hi = {{22{t[41]}}, t[41:32]};
        end else begin
            s = m_lo + pr;
            if (pr[31] == m_lo[31] && s[31] != pr[31]) begin
                m_hi = m_hi | 32'h1;
                m_lo = pr[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
            end else begin
                m_lo = s;
            end
        end
    endtask

    task automatic do_mac(input logic [15:0] a, input logic [15:0] b, input logic sat,
                          input string req);
        @(negedge clk);
        drive_idle();
        mac_go = 1; mac_sat = sat; op_a = a; op_b = b;
        model_mac(a, b, sat);
        push(1'b0, 1'b1, req);
    endtask

    task automatic do_write(input logic hi, input logic lo, input logic [31:0] d,
                            input string req);
        @(negedge clk);
        drive_idle();
        wr_hi = hi; wr_lo = lo; wr_data = d;
        if (hi) m_hi = d;
        if (lo) m_lo = d;
        push(1'b0, 1'b1, req);
    endtask

    task automatic do_clear(input string req);
        @(negedge clk);
        drive_idle();
        clr = 1;
        m_hi = '0; m_lo = '0;
        push(1'b0, 1'b1, req);
    endtask

    // Full multiply; noise=1 pokes every ignored input in the busy cycle,
    // abort=1 raises clr there, with_mac=1 raises mac_go with mul_go.
    task automatic do_mul(input logic [31:0] a, input logic [31:0] b, input logic sgn,
                          input bit noise, input bit abort, input bit with_mac,
                          input string req);
        logic [63:0] p;
        @(negedge clk);
        drive_idle();
        mul_go = 1; mul_a = a; mul_b = b; mul_signed = sgn;
        if (with_mac) begin
            mac_go = 1; op_a = 16'h0003; op_b = 16'h0005;
        end
        if (sgn) p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
        else     p = {32'h0, a} * {32'h0, b};
        push(1'b1, 1'b0, "R9 busy cycle");
        @(negedge clk);
        drive_idle();
        if (noise) begin
            mac_go = 1; op_a = 16'h7FFF; op_b = 16'h7FFF;
            mul_go = 1; mul_a = 32'h1234_5678; mul_b = 32'h9;
            wr_hi = 1; wr_lo = 1; wr_data = 32'hDEAD_BEEF;
        end
        if (abort) begin
            clr = 1;
            m_hi = '0; m_lo = '0;
        end else begin
            m_hi = p[63:32]; m_lo = p[31:0];
        end
        push(1'b0, 1'b1, req);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        drive_idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push(1'b0, 1'b1, "R12 reset state");

        do_mac(16'd3, 16'd4, 1'b0, "R1 small product");
        do_mac(16'hFFFB, 16'd7, 1'b0, "R2 negative product borrows high");
        do_mac(16'h8000, 16'h8000, 1'b0, "R1 most negative squared");

        // Carry out of low word into high word.
        do_write(1'b1, 1'b0, 32'h0, "R8 write high");
        do_write(1'b0, 1'b1, 32'hFFFF_FFFF, "R8 write low");
        do_mac(16'd1, 16'd1, 1'b0, "R2 carry into high");

        // High word crosses bit 9 and is sign-extended.
        do_write(1'b1, 1'b0, 32'h0000_01FF, "R8 write high");
        do_write(1'b0, 1'b1, 32'hFFFF_FFFF, "R8 write low");
        do_mac(16'd1, 16'd1, 1'b0, "R3 high sign-extended from bit 9");

        // Saturating mode.
        do_clear("R7 clear");
        do_write(1'b1, 1'b0, 32'h1234_5678, "R8 write high");
        do_mac(16'd100, 16'd200, 1'b1, "R4 no overflow keeps high");
        do_write(1'b0, 1'b1, 32'h7FFF_FFF0, "R8 write low");
        do_mac(16'h0100, 16'h0100, 1'b1, "R5 positive clamp");
        do_mac(16'd1, 16'hFFFF, 1'b1, "R6 sticky survives plain sum");
        do_write(1'b0, 1'b1, 32'h8000_0010, "R8 write low");
        do_mac(16'h0100, 16'hFF00, 1'b1, "R5 negative clamp");
        do_mac(16'd2, 16'd2, 1'b1, "R6 sticky after clamp");

        // Collisions.
        @(negedge clk);
        drive_idle();
        clr = 1; mac_go = 1; op_a = 16'd9; op_b = 16'd9; wr_lo = 1; wr_data = 32'h55;
        m_hi = '0; m_lo = '0;
        push(1'b0, 1'b1, "R7 clear beats write and strobe");

        @(negedge clk);
        drive_idle();
        wr_lo = 1; wr_data = 32'h0000_0005; mac_go = 1; op_a = 16'd10; op_b = 16'd10;
        m_lo = 32'h5;
        push(1'b0, 1'b1, "R8 write beats strobe");

        @(negedge clk);
        drive_idle();
        wr_hi = 1; wr_data = 32'h0000_0007; mul_go = 1; mul_a = 32'd3; mul_b = 32'd3;
        m_hi = 32'h7;
        push(1'b0, 1'b1, "R8 write beats multiply");

        // Full multiplies.
        do_mul(32'hFFFF_FFFF, 32'd2, 1'b1, 0, 0, 0, "R9 signed -1*2");
        do_mul(32'hFFFF_FFFF, 32'd2, 1'b0, 0, 0, 0, "R9 unsigned max*2");
        do_mul(32'h8000_0000, 32'h8000_0000, 1'b1, 0, 0, 0, "R9 signed min squared");
        do_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0, 0, 0, "R9 unsigned max squared");
        do_mul(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 1, 0, 0, "R10 inputs ignored while busy");
        do_mul(32'h0001_0003, 32'hFFFE_0001, 1'b1, 0, 0, 1, "R11 multiply beats strobe");
        do_mul(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 0, 1, 0, "R7 clear aborts multiply");

        // Mixed random accumulations from a cleared pair.
        do_clear("R7 clear");
        for (int i = 0; i < 40; i++) begin
            do_mac(16'($urandom), 16'($urandom), 1'($urandom), "R2/R4 random accumulate");
        end
        for (int i = 0; i < 6; i++) begin
            do_mul($urandom, $urandom, 1'($urandom), 0, 0, 0, "R9 random multiply");
        end

        @(negedge clk);
        drive_idle();
        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: got %0d pending, expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule